// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a chip against runaway software. One write port carries a strobe, an enable bit and a key of `KEY_W` bits (3 by default). While the watchdog is idle, a write with the enable bit set arms it and latches the supplied key. Once armed, the only accepted service is a write whose key equals the bitwise complement of the key it currently holds. Such a write either re-arms the timeout, when the enable bit is 1, or disarms the watchdog, when the enable bit is 0. Any other key merely replaces the held key.

When the watchdog is armed and `NMI_CYCLES` clock cycles pass without service, it raises a non-maskable interrupt request. That request stays high for a grace period of `GRACE_CYCLES` cycles. If no service arrives in that period, the block emits a one-cycle chip-reset pulse and falls back to idle. Both intervals are given in clock cycles. At 50 MHz the defaults give 0.1 s and 3.3 ms. The arm state and the held key can be read back as status.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the watchdog is idle (`armed`=0), `key_now` is 0, and `nmi_req` and `chip_rst` are low.
- R2: While idle, a write with `wr_enable`=0 has no effect: `armed` and `key_now` keep their values and no interrupt or reset follows.
- R3: While idle, a write with `wr_enable`=1 arms the watchdog on that clock edge, stores `wr_key` as the held key and starts the timeout from zero.
- R4: While armed, a write whose key is the bitwise NOT of the held key and whose `wr_enable`=0 disarms the watchdog and drops a pending `nmi_req` on the same edge.
- R5: While armed, a write whose key is the bitwise NOT of the held key and whose `wr_enable`=1 restarts the timeout from zero, stores the written key and drops a pending `nmi_req`.
- R6: While armed, a write with any other key only replaces the held key. `wr_enable` is ignored, and the running timeout and any pending interrupt continue unchanged.
- R7: `nmi_req` rises exactly `NMI_CYCLES` clock edges after the edge that armed or last restarted the watchdog, if no service occurred in between.
- R8: `chip_rst` is a one-cycle pulse that occurs exactly `GRACE_CYCLES` edges after `nmi_req` rose, if no service occurred. On that edge `nmi_req` falls and the watchdog becomes idle, while the held key is kept.
- R9: A valid service write that lands in the same cycle as an interval expiry takes precedence: no interrupt is raised, or no reset is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_enable | input | 1 | Enable bit carried by the write |
| wr_key | input | KEY_W | Key carried by the write |
| nmi_req | output | 1 | Non-maskable interrupt request, first escalation stage |
| chip_rst | output | 1 | One-cycle chip-reset pulse, second escalation stage |
| armed | output | 1 | Status: watchdog is running |
| key_now | output | KEY_W | Status: currently held key |

## Verification
A service write and an interval expiry can fall on the same clock edge. This can happen with the interrupt deadline or with the grace deadline. The bench provokes both cases on purpose by counting idle cycles from the arming edge and placing a restart or stop write exactly on the last cycle of each interval. A reference model in the bench decides the expected outcome: the service wins, so neither `nmi_req` nor `chip_rst` may appear. A mismatching-key write placed on the same expiry edge must let the escalation go ahead.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_START,
    ACT_RESTART,
    ACT_STOP,
    ACT_REKEY
  } kwd_act_e;

  typedef enum logic {
    PH_WAIT,
    PH_GRACE
  } kwd_phase_e;

endpackage

// File: rtl/kwd_keyctl.sv
module kwd_keyctl
  import kwd_pkg::*;
#(
  parameter int KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_enable,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             expire,
  output logic             running,
  output logic [KEY_W-1:0] key_q,
  output logic             kick,
  output kwd_act_e         act
);

  function automatic logic [KEY_W-1:0] inv_key(input logic [KEY_W-1:0] k);
    return ~k;
  endfunction

  function automatic kwd_act_e decode(input logic we, input logic en, input logic run,
                                      input logic [KEY_W-1:0] held,
                                      input logic [KEY_W-1:0] wk);
    kwd_act_e a;
    a = ACT_NONE;
    if (we) begin
      if (!run)                  a = en ? ACT_START : ACT_NONE;
      else if (wk == inv_key(held)) a = en ? ACT_RESTART : ACT_STOP;
      else                       a = ACT_REKEY;
    end
    return a;
  endfunction

  always_comb begin
    act  = decode(wr_en, wr_enable, running, key_q, wr_key);
    kick = (act == ACT_START) || (act == ACT_RESTART) || (act == ACT_STOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      key_q   <= '0;
    end else begin
      if (act == ACT_START || act == ACT_RESTART || act == ACT_REKEY)
        key_q <= wr_key;
      if (act == ACT_START)
        running <= 1'b1;
      else if (act == ACT_STOP || expire)
        running <= 1'b0;
    end
  end

  AST_IDLE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_enable && !running) |=> (!running && $stable(key_q))); // R2
  AST_START_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_enable && !running) |=> (running && key_q == $past(wr_key))); // R3
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_enable && running && wr_key == ~key_q) |=> !running); // R4
  AST_REKEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && running && wr_key != ~key_q && !expire) |=> (running && key_q == $past(wr_key))); // R6

endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
  import kwd_pkg::*;
#(
  parameter int NMI_CYCLES   = 5_000_000,
  parameter int GRACE_CYCLES = 165_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic kick,
  output logic nmi_req,
  output logic chip_rst,
  output logic nmi_fire,
  output logic expire
);

  localparam int MAX_CYC = (NMI_CYCLES > GRACE_CYCLES) ? NMI_CYCLES : GRACE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  kwd_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             advance;
  logic             at_limit;

  function automatic logic [CNT_W-1:0] limit_of(input kwd_phase_e ph);
    return (ph == PH_WAIT) ? CNT_W'(NMI_CYCLES - 1) : CNT_W'(GRACE_CYCLES - 1);
  endfunction

  always_comb begin
    advance  = running && !kick;
    at_limit = (cnt == limit_of(phase));
    nmi_fire = advance && (phase == PH_WAIT)  && at_limit;
    expire   = advance && (phase == PH_GRACE) && at_limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_WAIT;
      cnt      <= '0;
      nmi_req  <= 1'b0;
      chip_rst <= 1'b0;
    end else begin
      chip_rst <= expire;
      if (!advance) begin
        phase   <= PH_WAIT;
        cnt     <= '0;
        nmi_req <= 1'b0;
      end else if (nmi_fire) begin
        phase   <= PH_GRACE;
        cnt     <= '0;
        nmi_req <= 1'b1;
      end else if (expire) begin
        phase   <= PH_WAIT;
        cnt     <= '0;
        nmi_req <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!nmi_req && !chip_rst)); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst); // R8
  AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> ($past(nmi_req) && !nmi_req && !running)); // R8
  AST_NMI_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(running)); // R7

endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
  import kwd_pkg::*;
#(
  parameter int KEY_W        = 3,
  parameter int NMI_CYCLES   = 5_000_000,
  parameter int GRACE_CYCLES = 165_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_enable,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             chip_rst,
  output logic             armed,
  output logic [KEY_W-1:0] key_now
);

  logic     kick;
  logic     expire;
  logic     nmi_fire;
  kwd_act_e act;

  kwd_keyctl #(.KEY_W(KEY_W)) u_keyctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_enable(wr_enable),
    .wr_key   (wr_key),
    .expire   (expire),
    .running  (armed),
    .key_q    (key_now),
    .kick     (kick),
    .act      (act)
  );

  kwd_timer #(.NMI_CYCLES(NMI_CYCLES), .GRACE_CYCLES(GRACE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (armed),
    .kick    (kick),
    .nmi_req (nmi_req),
    .chip_rst(chip_rst),
    .nmi_fire(nmi_fire),
    .expire  (expire)
  );

  AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RESTART || act == ACT_STOP) |-> (!nmi_fire && !expire)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !nmi_req); // R1

endmodule

// File: tb/kwd_watchdog_test.sv
module kwd_watchdog_test;
  localparam int KW = 3;
  localparam int N  = 40;
  localparam int G  = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_enable = 1'b0;
  logic [KW-1:0] wr_key = '0;
  logic          nmi_req, chip_rst, armed;
  logic [KW-1:0] key_now;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  bit          m_run, m_nmi, m_rst, m_ph;
  logic [KW-1:0] m_key;
  int          m_cnt;

  always #10 clk = ~clk;

  kwd_watchdog #(.KEY_W(KW), .NMI_CYCLES(N), .GRACE_CYCLES(G)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_enable(wr_enable), .wr_key(wr_key),
    .nmi_req(nmi_req), .chip_rst(chip_rst), .armed(armed), .key_now(key_now)
  );

  function automatic logic [KW-1:0] complement(input logic [KW-1:0] k);
    return k ^ {KW{1'b1}};
  endfunction

  // advance the reference by one edge; returns the requirement most concerned
  function automatic string model_step(input bit we, input bit en, input logic [KW-1:0] k);
    bit svc = 1'b0;
    bit due;
    string tag = "R7";
    due = m_run && (m_cnt == ((m_ph == 0) ? N - 1 : G - 1));
    m_rst = 1'b0;
    if (we) begin
      if (!m_run) begin
        if (en) begin m_run = 1; m_key = k; svc = 1; tag = "R3"; end
        else tag = "R2";
      end else if (k == complement(m_key)) begin
        svc = 1;
        if (en) begin m_key = k; tag = "R5"; end
        else begin m_run = 0; tag = "R4"; end
        if (due) tag = "R9";
      end else begin
        m_key = k; tag = "R6";
      end
    end
    if (svc || !m_run) begin
      m_cnt = 0; m_ph = 0; m_nmi = 0;
    end else if (due && m_ph == 0) begin
      m_nmi = 1; m_ph = 1; m_cnt = 0; tag = "R7";
    end else if (due) begin
      m_rst = 1; m_run = 0; m_nmi = 0; m_ph = 0; m_cnt = 0; tag = "R8";
    end else begin
      m_cnt++;
    end
    return tag;
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (nmi_req !== m_nmi || chip_rst !== m_rst || armed !== m_run || key_now !== m_key) begin
      miscompares++;
      $display("FAIL %s: nmi=%0b rst=%0b armed=%0b key=%0d expected nmi=%0b rst=%0b armed=%0b key=%0d",
               tag, nmi_req, chip_rst, armed, key_now, m_nmi, m_rst, m_run, m_key);
    end
  endtask

  task automatic step(input bit we, input bit en, input logic [KW-1:0] k);
    string tag;
    wr_en = we; wr_enable = en; wr_key = k;
    tag = model_step(we, en, k);
    @(negedge clk);
    wr_en = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_run = 0; m_nmi = 0; m_rst = 0; m_ph = 0; m_key = '0; m_cnt = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: disabled write while idle does nothing, no escalation later
    step(1'b1, 1'b0, 3'd5);
    idle(N + G + 4);
    // R3 start, R6 rekey with enable ignored, R7/R8 full escalation
    step(1'b1, 1'b1, 3'd3);
    idle(10);
    step(1'b1, 1'b0, 3'd6);
    idle(N + G + 3);
    // R9: restart exactly on interrupt deadline
    step(1'b1, 1'b1, 3'd1);
    idle(N - 1);
    step(1'b1, 1'b1, complement(3'd1));
    idle(N);
    // now in grace; R9: stop exactly on grace deadline
    idle(G - 1);
    step(1'b1, 1'b0, 3'd1);
    idle(5);
    // R4: stop while interrupt pending, R5 restart while pending
    step(1'b1, 1'b1, 3'd0);
    idle(N + 2);
    step(1'b1, 1'b1, 3'd7);
    idle(N + 1);
    step(1'b1, 1'b0, 3'd0);
    idle(3);
    // R6: mismatching key on the deadline lets escalation go ahead
    step(1'b1, 1'b1, 3'd2);
    idle(N - 1);
    step(1'b1, 1'b1, 3'd4);
    idle(G + 3);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [KW-1:0] k;
      r = $urandom % 100;
      k = KW'($urandom);
      if (r < 3)       step(1'b1, 1'($urandom), complement(m_key));
      else if (r < 5)  step(1'b1, 1'($urandom), (k == complement(m_key)) ? m_key : k);
      else if (r < 7)  step(1'b1, 1'($urandom), k);
      else             step(1'b0, 1'b0, '0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule